// File: doc/BRIEF.md
# Dual Data Pointer Register Bank

This block is a special-function-register slice for an 8-bit microcontroller core. It holds two 16-bit pointers into external data memory and a small auxiliary control register. A select bit in that control register decides which of the two physical pointers the shared low-byte and high-byte register addresses reach. The other pointer is left untouched and is not visible through those addresses while it is deselected.

The core reaches the bank over a byte-wide register bus made of an address, write data, a write enable, a read enable and read data. The active pointer is driven out continuously as the external data memory address. An increment strobe from the core steps the active pointer by one. The control register also holds a boot-mapping enable. A combinational decode uses it to flag code-fetch addresses that fall in the top 2 KiB of the code space, F800h to FFFFh.

Top module: `dptr_bank`

## Requirements
- R1: After reset both pointers hold 0000h, the control register reads 00h, pointer 0 is selected and boot mapping is off.
- R2: Bit 0 of the control register (address A2h) is the select: 0 chooses pointer 0 and 1 chooses pointer 1. `xmem_addr` always shows the selected pointer.
- R3: Address 82h reaches the low byte and address 83h the high byte of the selected pointer only. The other pointer is neither read nor changed.
- R4: Bit 3 of the control register is a user flag that software can write and read back freely.
- R5: Bit 2 of the control register always reads 0, whatever value is written to it.
- R6: Bits 7, 6, 4 and 1 of the control register are not stored and always read 0.
- R7: Bit 5 of the control register is the boot enable. `boot_sel` is high exactly when the boot enable is set and bits 15:11 of `fetch_addr` are all ones.
- R8: An `inc` pulse adds one to the selected pointer. The carry passes from the low byte into the high byte, FFFFh wraps to 0000h, and the other pointer keeps its value.
- R9: A select write takes effect at the next clock edge. A pointer byte access or increment in the same cycle uses the old selection.
- R10: A read of any address other than 82h, 83h or A2h returns 00h, and a write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write enable |
| reg_re | input | 1 | Read enable |
| reg_rdata | output | 8 | Combinational read data, 00h when no read is active |
| inc | input | 1 | Increment the selected pointer |
| xmem_addr | output | 16 | Selected pointer value |
| fetch_addr | input | 16 | Code fetch address |
| boot_sel | output | 1 | Fetch address maps to the boot ROM |

## Verification
The hardest case to reach from the ports is a cycle in which the select bit changes while a pointer write or increment hits the shared addresses. To create it, the bench writes the control register while it pulses `inc` in the same cycle. Both pointers are then read back to show which one moved. The carry path is driven by loading pointer bytes near FFh, and the boot decode is swept over every value of the top five fetch-address bits with the enable both on and off.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int PW = 16;
    localparam logic [AW-1:0] ADDR_LO  = 8'h82;
    localparam logic [AW-1:0] ADDR_HI  = 8'h83;
    localparam logic [AW-1:0] ADDR_CTL = 8'hA2;
    localparam int SEL_BIT  = 0;
    localparam int ZERO_BIT = 2;
    localparam int FLAG_BIT = 3;
    localparam int BOOT_BIT = 5;

    typedef struct packed {
        logic sel;
        logic flag;
        logic boot;
    } ctl_t;
endpackage

// File: rtl/dptr_ctl.sv
module dptr_ctl
    import dptr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output ctl_t          ctl,
    output logic [DW-1:0] rd_img
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) begin
            ctl_d.sel  = wdata[SEL_BIT];
            ctl_d.flag = wdata[FLAG_BIT];
            ctl_d.boot = wdata[BOOT_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rd_img = '0;
        rd_img[SEL_BIT]  = ctl_q.sel;
        rd_img[FLAG_BIT] = ctl_q.flag;
        rd_img[BOOT_BIT] = ctl_q.boot;
    end

    assign ctl = ctl_q;

    // R5 R6
    always_comb begin
        reserved_zero_chk: assert (!rst_n || (rd_img & 8'hD6) == 8'h00);
    end
endmodule

// File: rtl/dptr_ptr.sv
module dptr_ptr
    import dptr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic          inc,
    input  logic [DW-1:0] wdata,
    output logic [PW-1:0] val
);
    logic [PW-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (en) begin
            if (wr_lo)      val_d[DW-1:0]  = wdata;
            else if (wr_hi) val_d[PW-1:DW] = wdata;
            else if (inc)   val_d = val_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;

    // R3 R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(val_q));
    // R8
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && inc && !wr_lo && !wr_hi) |=> val_q == PW'($past(val_q) + 1));
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
    import dptr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_we,
    input  logic        reg_re,
    output logic [7:0]  reg_rdata,
    input  logic        inc,
    output logic [15:0] xmem_addr,
    input  logic [15:0] fetch_addr,
    output logic        boot_sel
);
    localparam int NPTR = 2;
    localparam int BOOT_MSB = 5;

    ctl_t          ctl;
    logic [DW-1:0] ctl_img;
    logic [PW-1:0] ptr_val [NPTR];
    logic          hit_lo, hit_hi, hit_ctl;

    assign hit_lo  = reg_addr == ADDR_LO;
    assign hit_hi  = reg_addr == ADDR_HI;
    assign hit_ctl = reg_addr == ADDR_CTL;

    dptr_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(reg_we && hit_ctl),
        .wdata(reg_wdata), .ctl(ctl), .rd_img(ctl_img)
    );

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        dptr_ptr u_ptr (
            .clk(clk), .rst_n(rst_n),
            .en(ctl.sel == 1'(i)),
            .wr_lo(reg_we && hit_lo),
            .wr_hi(reg_we && hit_hi),
            .inc(inc),
            .wdata(reg_wdata),
            .val(ptr_val[i])
        );
    end

    logic [PW-1:0] cur;
    assign cur       = ptr_val[ctl.sel];
    assign xmem_addr = cur;

    always_comb begin
        reg_rdata = '0;
        if (reg_re) begin
            if (hit_lo)       reg_rdata = cur[DW-1:0];
            else if (hit_hi)  reg_rdata = cur[PW-1:DW];
            else if (hit_ctl) reg_rdata = ctl_img;
        end
    end

    assign boot_sel = ctl.boot && (&fetch_addr[PW-1:PW-BOOT_MSB]);

    // R7
    always_comb begin
        boot_off_chk: assert (!rst_n || ctl.boot || !boot_sel);
    end
    // R9
    sel_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && hit_ctl) |=> ctl.sel == $past(reg_wdata[SEL_BIT]));
    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && hit_ctl) |=> $stable(ctl.sel));
endmodule

// File: tb/dptr_bank_test.sv
module dptr_bank_test;
    logic        clk = 0, rst_n = 0;
    logic [7:0]  reg_addr = 0, reg_wdata = 0;
    logic        reg_we = 0, reg_re = 0, inc = 0;
    logic [7:0]  reg_rdata;
    logic [15:0] xmem_addr, fetch_addr = 0;
    logic        boot_sel;
    int checks = 0, errors = 0;
    logic [15:0] m0, m1;
    logic msel, mboot;

    always #2 clk = ~clk;

    dptr_bank uut (.*);

    task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_re = 1; #1 d = reg_rdata; reg_re = 0;
    endtask

    task automatic pulse_inc();
        @(negedge clk); inc = 1; @(negedge clk); inc = 0;
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog act=hung exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk); rst_n = 1;
        // R1
        rd(8'h82, d); chk("R1 lo", d, 0);
        rd(8'h83, d); chk("R1 hi", d, 0);
        rd(8'hA2, d); chk("R1 ctl", d, 0);
        chk("R1 xmem", xmem_addr, 0);
        chk("R1 boot", boot_sel, 0);
        // R3 R2: load both pointers
        wr(8'h82, 8'h34); wr(8'h83, 8'h12);
        wr(8'hA2, 8'h01);
        chk("R3 other untouched", xmem_addr, 16'h0000);
        wr(8'h82, 8'hCD); wr(8'h83, 8'hAB);
        chk("R2 sel1 xmem", xmem_addr, 16'hABCD);
        wr(8'hA2, 8'h00);
        chk("R2 sel0 xmem", xmem_addr, 16'h1234);
        rd(8'h82, d); chk("R3 lo0", d, 8'h34);
        rd(8'h83, d); chk("R3 hi0", d, 8'h12);
        // R4 R5 R6: sweep all control write values
        for (int v = 0; v < 256; v++) begin
            wr(8'hA2, 8'(v));
            rd(8'hA2, d);
            chk("R4 R5 R6 ctl readback", d, 16'(v & 8'h29));
        end
        wr(8'hA2, 8'h00);
        // R8 carry and wrap on pointer 1 while pointer 0 holds
        m0 = 16'h1234;
        for (int k = 0; k < 4; k++) begin
            logic [15:0] s;
            s = (k == 0) ? 16'h00FF : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h12FE : 16'h7FFF;
            wr(8'hA2, 8'h01);
            wr(8'h82, s[7:0]); wr(8'h83, s[15:8]);
            pulse_inc(); pulse_inc();
            chk("R8 inc", xmem_addr, 16'(s + 2));
            wr(8'hA2, 8'h00);
            chk("R8 other held", xmem_addr, m0);
        end
        // R9: select write together with inc uses old selection
        // pointer0=1234, pointer1=8001
        @(negedge clk); reg_addr = 8'hA2; reg_wdata = 8'h01; reg_we = 1; inc = 1;
        @(negedge clk); reg_we = 0; inc = 0;
        chk("R9 new sel ptr1 unchanged", xmem_addr, 16'h8001);
        wr(8'hA2, 8'h00);
        chk("R9 old sel ptr0 bumped", xmem_addr, 16'h1235);
        // R10 unmapped
        wr(8'h84, 8'hFF); wr(8'h81, 8'h55);
        rd(8'h84, d); chk("R10 read 00", d, 0);
        chk("R10 no effect", xmem_addr, 16'h1235);
        rd(8'hA2, d); chk("R10 ctl kept", d, 0);
        // R7 boot decode sweep
        for (int e = 0; e < 2; e++) begin
            wr(8'hA2, e ? 8'h20 : 8'h00);
            for (int t = 0; t < 32; t++) begin
                @(negedge clk); fetch_addr = {5'(t), 11'h3A5};
                #1 chk("R7 boot_sel", boot_sel, (e == 1 && t == 31));
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule